// File: doc/BRIEF.md
# Split read completion tracker

This block sits between the intake of a memory read path and the response return path. An upstream splitter breaks each parent read into one or more pieces, each no wider than one DRAM burst, and sends them here one at a time, all tagged with the parent's tag. Each piece is checked in parallel against every live write-queue entry. A piece that the write queue can supply is counted as already serviced and never reaches the read path. A piece that misses is passed straight on to the read path, carrying its parent's tag.

A parent of more than one piece gets a tracking entry, selected by its tag, when its first piece arrives. The entry holds the piece total and a serviced count. The serviced count is preloaded by forwarded pieces and advanced by DRAM completions. The parent's single response leaves the cycle after the count reaches the total. When every piece is forwarded, the response comes without any DRAM access. A single-piece miss needs no entry: its one completion produces the response directly. When piece intake has been stalled, a retry pulse is raised as soon as a tracking entry or the response hold slot becomes free.

Top module: `split_read_tracker`

## Requirements
- R1: A piece hits the write queue only when some valid entry has an address equal to the piece address and a size greater than or equal to the piece size. An address or size mismatch is a miss.
- R2: A missing piece is presented on `rd_valid` with its tag, address and size in the cycle it is accepted. A hitting piece is never presented there.
- R3: A parent whose pieces all hit produces one response, carrying its tag, in the cycle after its last piece is accepted, unless R6 delays it.
- R4: A parent with more than one piece and at least one miss produces exactly one response. It comes in the cycle after the completion that brings its serviced count (forwarded pieces plus completions) to its piece count. A completion arriving together with the finishing forwarded piece still yields one response.
- R5: A parent of one piece (first and last both set) that misses responds in the cycle after its one completion, and uses no tracking entry.
- R6: When a completion response and a forwarded response fall due in the same cycle, the completion response goes out first and the forwarded one in the following cycle.
- R7: `piece_ready` is low while a forwarded response is held back, and while a first, non-last piece names a tag whose tracking entry is still in use.
- R8: A piece offered while `piece_ready` is low sets a pending-retry flag. `rd_retry` pulses for one cycle after the next cycle in which a tracking entry frees or the held response leaves, and the flag then clears.
- R9: During and right after reset no response or retry is shown, and all tracking entries are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| piece_valid | input | 1 | A read piece is offered |
| piece_ready | output | 1 | The piece is accepted this cycle |
| piece_tag | input | TAG_W | Parent tag of the piece |
| piece_addr | input | ADDR_W | Piece start address |
| piece_size | input | SIZE_W | Piece size in bytes |
| piece_first | input | 1 | First piece of its parent |
| piece_last | input | 1 | Last piece of its parent |
| piece_count | input | CNT_W | Piece count of the parent, sampled with the first piece |
| wq_valid | input | WQ_DEPTH | Write-queue entry live flags |
| wq_addr | input | WQ_DEPTH*ADDR_W | Write-queue entry addresses, entry i at bits i*ADDR_W |
| wq_size | input | WQ_DEPTH*SIZE_W | Write-queue entry sizes, entry i at bits i*SIZE_W |
| rd_valid | output | 1 | A missing piece goes to the read path |
| rd_tag | output | TAG_W | Parent tag of that piece |
| rd_addr | output | ADDR_W | Address of that piece |
| rd_size | output | SIZE_W | Size of that piece |
| cmp_valid | input | 1 | A DRAM burst read has completed |
| cmp_tag | input | TAG_W | Parent tag of the completed burst |
| resp_valid | output | 1 | Parent response pulse |
| resp_tag | output | TAG_W | Tag of the responding parent |
| rd_retry | output | 1 | Retry pulse for a stalled requester |

## Verification
On every cycle the assertions check these rules: read-path issue only happens on an accepted piece; intake is blocked while a response is held; every completion that finishes a parent produces a response with that tag in the next cycle; a colliding forwarded response lands in the hold slot; every response and every retry pulse has a cause in the cycle before. The full hit rule, the exact count at which a split parent finishes, the single-piece path and the ordering of a delayed forwarded response can only be shown by the bench's scenarios. The bench follows them against its behavioural model, with directed tags, sizes and collisions.

// File: rtl/srt_pkg.sv
package srt_pkg;
   // source selected for the registered response output
   typedef enum logic [1:0] {
      RS_IDLE,
      RS_CMP,
      RS_HOLD,
      RS_FWD
   } rsp_src_e;
endpackage

// File: rtl/srt_wq_match.sv
module srt_wq_match #(
   parameter int ADDR_W   = 32,
   parameter int SIZE_W   = 7,
   parameter int WQ_DEPTH = 8
) (
   input  logic [WQ_DEPTH-1:0]        wq_valid,
   input  logic [WQ_DEPTH*ADDR_W-1:0] wq_addr,
   input  logic [WQ_DEPTH*SIZE_W-1:0] wq_size,
   input  logic [ADDR_W-1:0]          q_addr,
   input  logic [SIZE_W-1:0]          q_size,
   output logic                       hit
);
   logic [WQ_DEPTH-1:0] match;

   // every entry compared at once; entry must cover the whole piece
   for (genvar i = 0; i < WQ_DEPTH; i++) begin : g_cmp
      assign match[i] = wq_valid[i]
                     && (wq_addr[i*ADDR_W +: ADDR_W] == q_addr)
                     && (wq_size[i*SIZE_W +: SIZE_W] >= q_size);
   end

   assign hit = |match;
endmodule

// File: rtl/srt_track_table.sv
module srt_track_table #(
   parameter int NUM_TAGS = 8,
   parameter int TAG_W    = 3,
   parameter int CNT_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                alloc,
   input  logic [TAG_W-1:0]    alloc_tag,
   input  logic [CNT_W-1:0]    alloc_total,
   input  logic                alloc_hit,
   input  logic                inc,
   input  logic [TAG_W-1:0]    inc_tag,
   input  logic                cmp,
   input  logic [TAG_W-1:0]    cmp_tag,
   output logic [NUM_TAGS-1:0] busy,
   output logic [NUM_TAGS-1:0] fin
);
   for (genvar i = 0; i < NUM_TAGS; i++) begin : g_ent
      logic             busy_q;
      logic [CNT_W-1:0] total_q;
      logic [CNT_W-1:0] served_q;
      logic [CNT_W-1:0] served_nx;
      logic             sel_alloc;
      logic             sel_inc;
      logic             sel_cmp;

      assign sel_alloc = alloc && (alloc_tag == TAG_W'(i));
      assign sel_inc   = inc && (inc_tag == TAG_W'(i)) && busy_q;
      assign sel_cmp   = cmp && (cmp_tag == TAG_W'(i)) && busy_q;
      // a forwarded piece and a completion may both land in one cycle
      assign served_nx = served_q + CNT_W'(sel_inc) + CNT_W'(sel_cmp);
      assign fin[i]    = busy_q && (sel_inc || sel_cmp) && (served_nx == total_q);
      assign busy[i]   = busy_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy_q   <= 1'b0;
            total_q  <= '0;
            served_q <= '0;
         end else if (sel_alloc) begin
            busy_q   <= 1'b1;
            total_q  <= alloc_total;
            served_q <= CNT_W'(alloc_hit);
         end else if (fin[i]) begin
            busy_q   <= 1'b0;
            served_q <= '0;
         end else if (sel_inc || sel_cmp) begin
            served_q <= served_nx;
         end
      end
   end
endmodule

// File: rtl/srt_resp_stage.sv
module srt_resp_stage
   import srt_pkg::*;
#(
   parameter int TAG_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             c_ev,
   input  logic [TAG_W-1:0] c_tag,
   input  logic             f_ev,
   input  logic [TAG_W-1:0] f_tag,
   input  logic             stall,
   input  logic             freed,
   output logic             resp_valid,
   output logic [TAG_W-1:0] resp_tag,
   output logic             hold_busy,
   output logic             retry_pend,
   output logic             rd_retry
);
   rsp_src_e         src;
   logic             hold_q;
   logic [TAG_W-1:0] hold_tag;
   logic             flag_q;
   logic             pend;
   logic             slot_free;

   always_comb begin
      if (c_ev)        src = RS_CMP;
      else if (hold_q) src = RS_HOLD;
      else if (f_ev)   src = RS_FWD;
      else             src = RS_IDLE;
   end

   assign slot_free  = freed || (hold_q && !c_ev);
   assign pend       = flag_q || stall;
   assign hold_busy  = hold_q;
   assign retry_pend = flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_tag   <= '0;
         hold_q     <= 1'b0;
         hold_tag   <= '0;
         flag_q     <= 1'b0;
         rd_retry   <= 1'b0;
      end else begin
         resp_valid <= (src != RS_IDLE);
         case (src)
            RS_CMP:  resp_tag <= c_tag;
            RS_HOLD: resp_tag <= hold_tag;
            RS_FWD:  resp_tag <= f_tag;
            default: resp_tag <= resp_tag;
         endcase
         if (c_ev && f_ev) begin
            hold_q   <= 1'b1;
            hold_tag <= f_tag;
         end else if (src == RS_HOLD) begin
            hold_q <= 1'b0;
         end
         rd_retry <= pend && slot_free;
         flag_q   <= pend && !slot_free;
      end
   end
endmodule

// File: rtl/split_read_tracker.sv
module split_read_tracker #(
   parameter int ADDR_W     = 32,
   parameter int SIZE_W     = 7,
   parameter int WQ_DEPTH   = 8,
   parameter int NUM_TAGS   = 8,
   parameter int MAX_PIECES = 8,
   localparam int TAG_W     = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1,
   localparam int CNT_W     = $clog2(MAX_PIECES + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       piece_valid,
   output logic                       piece_ready,
   input  logic [TAG_W-1:0]           piece_tag,
   input  logic [ADDR_W-1:0]          piece_addr,
   input  logic [SIZE_W-1:0]          piece_size,
   input  logic                       piece_first,
   input  logic                       piece_last,
   input  logic [CNT_W-1:0]           piece_count,
   input  logic [WQ_DEPTH-1:0]        wq_valid,
   input  logic [WQ_DEPTH*ADDR_W-1:0] wq_addr,
   input  logic [WQ_DEPTH*SIZE_W-1:0] wq_size,
   output logic                       rd_valid,
   output logic [TAG_W-1:0]           rd_tag,
   output logic [ADDR_W-1:0]          rd_addr,
   output logic [SIZE_W-1:0]          rd_size,
   input  logic                       cmp_valid,
   input  logic [TAG_W-1:0]           cmp_tag,
   output logic                       resp_valid,
   output logic [TAG_W-1:0]           resp_tag,
   output logic                       rd_retry
);
   if (NUM_TAGS < 2 || NUM_TAGS != (1 << TAG_W)) begin : g_bad_tags
      $error("NUM_TAGS must be a power of two, at least 2");
   end
   if (MAX_PIECES < 2) begin : g_bad_pieces
      $error("MAX_PIECES must be at least 2");
   end
   if (WQ_DEPTH < 1) begin : g_bad_wq
      $error("WQ_DEPTH must be at least 1");
   end

   logic                hit;
   logic                accept;
   logic                single;
   logic [NUM_TAGS-1:0] busy;
   logic [NUM_TAGS-1:0] fin;
   logic                cmp_tracked;
   logic                c_ev;
   logic                f_ev;
   logic                hold_busy;
   logic                retry_pend;

   srt_wq_match #(
      .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .WQ_DEPTH(WQ_DEPTH)
   ) u_match (
      .wq_valid(wq_valid), .wq_addr(wq_addr), .wq_size(wq_size),
      .q_addr(piece_addr), .q_size(piece_size), .hit(hit)
   );

   assign single      = piece_first && piece_last;
   assign piece_ready = !hold_busy && !(piece_first && !piece_last && busy[piece_tag]);
   assign accept      = piece_valid && piece_ready;

   srt_track_table #(
      .NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W), .CNT_W(CNT_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .alloc(accept && piece_first && !piece_last),
      .alloc_tag(piece_tag), .alloc_total(piece_count), .alloc_hit(hit),
      .inc(accept && !piece_first && hit), .inc_tag(piece_tag),
      .cmp(cmp_valid), .cmp_tag(cmp_tag),
      .busy(busy), .fin(fin)
   );

   assign cmp_tracked = cmp_valid && busy[cmp_tag];
   // completion responds when untracked or when it finishes its parent
   assign c_ev = cmp_valid && (!busy[cmp_tag] || fin[cmp_tag]);
   // forwarded finish: all-hit single piece, or last hit closing an entry
   assign f_ev = (accept && single && hit)
              || (accept && !piece_first && fin[piece_tag]
                  && !(cmp_tracked && (cmp_tag == piece_tag)));

   assign rd_valid = accept && !hit;
   assign rd_tag   = piece_tag;
   assign rd_addr  = piece_addr;
   assign rd_size  = piece_size;

   srt_resp_stage #(.TAG_W(TAG_W)) u_resp (
      .clk(clk), .rst_n(rst_n),
      .c_ev(c_ev), .c_tag(cmp_tag),
      .f_ev(f_ev), .f_tag(piece_tag),
      .stall(piece_valid && !piece_ready),
      .freed(|fin),
      .resp_valid(resp_valid), .resp_tag(resp_tag),
      .hold_busy(hold_busy), .retry_pend(retry_pend),
      .rd_retry(rd_retry)
   );
endmodule

// File: rtl/split_read_tracker_chk.sv
module split_read_tracker_chk #(
   parameter int TAG_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             piece_valid,
   input logic             piece_ready,
   input logic             rd_valid,
   input logic             cmp_valid,
   input logic [TAG_W-1:0] cmp_tag,
   input logic             resp_valid,
   input logic [TAG_W-1:0] resp_tag,
   input logic             c_ev,
   input logic             f_ev,
   input logic             hold_busy,
   input logic             retry_pend,
   input logic             rd_retry
);
   AST_RD_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (piece_valid && piece_ready)); // R2

   AST_HOLD_BLOCKS_INTAKE: assert property (@(posedge clk) disable iff (!rst_n)
      hold_busy |-> !piece_ready); // R7

   AST_CMP_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && c_ev) |=> (resp_valid && resp_tag == $past(cmp_tag))); // R4

   AST_COLLIDE_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (c_ev && f_ev) |=> hold_busy); // R6

   AST_RESP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> $past(c_ev || f_ev || hold_busy)); // R3

   AST_RETRY_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_retry |-> $past(retry_pend || (piece_valid && !piece_ready))); // R8
endmodule

bind split_read_tracker split_read_tracker_chk #(.TAG_W(TAG_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .piece_valid(piece_valid), .piece_ready(piece_ready),
   .rd_valid(rd_valid),
   .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
   .resp_valid(resp_valid), .resp_tag(resp_tag),
   .c_ev(c_ev), .f_ev(f_ev),
   .hold_busy(hold_busy), .retry_pend(retry_pend),
   .rd_retry(rd_retry)
);

// File: tb/split_read_tracker_bench.sv
`timescale 1ns/1ps
module split_read_tracker_bench;
   localparam int AW = 32;
   localparam int SW = 7;
   localparam int WQ = 8;
   localparam int TW = 3;
   localparam int CW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          pv = 0, pf = 0, pl = 0, cv = 0;
   logic [TW-1:0] pt = 0, ct = 0;
   logic [AW-1:0] pa = 0;
   logic [SW-1:0] ps = 0;
   logic [CW-1:0] pc = 0;

   logic          wq_v [WQ];
   logic [AW-1:0] wq_a [WQ];
   logic [SW-1:0] wq_s [WQ];
   logic [WQ-1:0]    wq_valid_f;
   logic [WQ*AW-1:0] wq_addr_f;
   logic [WQ*SW-1:0] wq_size_f;

   always_comb begin
      for (int i = 0; i < WQ; i++) begin
         wq_valid_f[i]          = wq_v[i];
         wq_addr_f[i*AW +: AW]  = wq_a[i];
         wq_size_f[i*SW +: SW]  = wq_s[i];
      end
   end

   logic          piece_ready, rd_valid, resp_valid, rd_retry;
   logic [TW-1:0] rd_tag, resp_tag;
   logic [AW-1:0] rd_addr;
   logic [SW-1:0] rd_size;

   split_read_tracker u_split_read_tracker (
      .clk(clk), .rst_n(rst_n),
      .piece_valid(pv), .piece_ready(piece_ready), .piece_tag(pt),
      .piece_addr(pa), .piece_size(ps), .piece_first(pf), .piece_last(pl),
      .piece_count(pc),
      .wq_valid(wq_valid_f), .wq_addr(wq_addr_f), .wq_size(wq_size_f),
      .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_addr(rd_addr), .rd_size(rd_size),
      .cmp_valid(cv), .cmp_tag(ct),
      .resp_valid(resp_valid), .resp_tag(resp_tag), .rd_retry(rd_retry)
   );

   int n_chk = 0, n_err = 0;
   bit done = 0;
   int resp_cnt [8];
   int rd_seen = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit m_busy [8];
   int m_total [8];
   int m_served [8];
   int fwdq [$];
   bit m_flag;
   bit exp_v, exp_retry;
   int exp_t;

   function automatic bit m_hit(input logic [AW-1:0] a, input logic [SW-1:0] s);
      for (int i = 0; i < WQ; i++)
         if (wq_v[i] && wq_a[i] == a && wq_s[i] >= s) return 1'b1;
      return 1'b0;
   endfunction

   function automatic bit m_ready();
      return (fwdq.size() == 0) && !(pf && !pl && m_busy[pt]);
   endfunction

   always @(posedge clk or negedge rst_n) begin : model
      bit acc, hit, cfire, ffire, freed, hold_before, stall, pend, slot;
      int ctag, ftag;
      bit touched [8];
      bit ctouch [8];
      if (!rst_n) begin
         for (int t = 0; t < 8; t++) begin
            m_busy[t] = 0; m_total[t] = 0; m_served[t] = 0;
         end
         fwdq.delete();
         m_flag = 0; exp_v = 0; exp_retry = 0; exp_t = 0;
      end else begin
         hold_before = (fwdq.size() > 0);
         acc   = pv && m_ready();
         stall = pv && !m_ready();
         hit   = m_hit(pa, ps);
         cfire = 0; ffire = 0; freed = 0; ctag = 0; ftag = 0;
         for (int t = 0; t < 8; t++) begin touched[t] = 0; ctouch[t] = 0; end
         if (cv) begin
            if (m_busy[ct]) begin
               m_served[ct]++; touched[ct] = 1; ctouch[ct] = 1;
            end else begin
               cfire = 1; ctag = ct;
            end
         end
         if (acc) begin
            if (pf && pl) begin
               if (hit) begin ffire = 1; ftag = pt; end
            end else if (pf) begin
               m_busy[pt] = 1; m_total[pt] = pc; m_served[pt] = hit;
            end else if (hit && m_busy[pt]) begin
               m_served[pt]++; touched[pt] = 1;
            end
         end
         for (int t = 0; t < 8; t++) begin
            if (touched[t] && m_served[t] == m_total[t]) begin
               m_busy[t] = 0; freed = 1;
               if (ctouch[t]) begin cfire = 1; ctag = t; end
               else begin ffire = 1; ftag = t; end
            end
         end
         exp_v = 0;
         if (cfire) begin exp_v = 1; exp_t = ctag; end
         if (ffire) fwdq.push_back(ftag);
         if (!cfire && fwdq.size() > 0) begin
            exp_v = 1; exp_t = fwdq.pop_front();
         end
         slot = freed || (hold_before && !cfire);
         pend = m_flag || stall;
         exp_retry = pend && slot;
         m_flag = pend && !slot;
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(negedge clk) begin
      #2;
      if (rst_n && !done) begin
         chk(resp_valid == exp_v, "R3", "resp_valid", resp_valid, exp_v);
         if (exp_v) chk(resp_tag == exp_t, "R4", "resp_tag", resp_tag, exp_t);
         chk(rd_retry == exp_retry, "R8", "rd_retry", rd_retry, exp_retry);
         chk(piece_ready == m_ready(), "R7", "piece_ready", piece_ready, m_ready());
         chk(rd_valid == (pv && m_ready() && !m_hit(pa, ps)), "R2", "rd_valid",
             rd_valid, pv && m_ready() && !m_hit(pa, ps));
         if (rd_valid) chk(rd_addr == pa && rd_tag == pt && rd_size == ps, "R2",
                           "rd_addr", rd_addr, pa);
         if (resp_valid) resp_cnt[resp_tag]++;
         if (rd_valid) rd_seen++;
      end
   end

   task automatic drv(input bit v, input int tag, input int addr, input int size,
                      input bit f, input bit l, input int cnt,
                      input bit c, input int ctg);
      @(negedge clk);
      pv = v; pt = TW'(tag); pa = AW'(addr); ps = SW'(size);
      pf = f; pl = l; pc = CW'(cnt); cv = c; ct = TW'(ctg);
   endtask

   task automatic idle_cyc();
      drv(0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      #1600000;
      if (!done) begin
         done = 1;
         n_chk++; n_err++;
         $display("FAIL watchdog R9 act=0 exp=1");
         summary();
         $finish;
      end
   end

   initial begin
      int seen0;
      for (int i = 0; i < 8; i++) resp_cnt[i] = 0;
      for (int i = 0; i < WQ; i++) begin wq_v[i] = 0; wq_a[i] = 0; wq_s[i] = 0; end
      wq_v[0] = 1; wq_a[0] = 32'h100; wq_s[0] = 32;
      wq_v[1] = 1; wq_a[1] = 32'h120; wq_s[1] = 16;
      wq_v[2] = 1; wq_a[2] = 32'h200; wq_s[2] = 64;

      // R9: reset state
      repeat (3) @(negedge clk);
      #3;
      chk(resp_valid == 0, "R9", "resp_valid in reset", resp_valid, 0);
      chk(rd_retry == 0, "R9", "rd_retry in reset", rd_retry, 0);
      rst_n = 1;
      idle_cyc(); #3;
      chk(piece_ready == 1, "R9", "piece_ready after reset", piece_ready, 1);
      chk(resp_valid == 0, "R9", "resp_valid after reset", resp_valid, 0);

      // R3: single piece fully forwarded
      drv(1, 1, 'h100, 32, 1, 1, 1, 0, 0);
      #3; chk(rd_seen == 0, "R2", "hit piece on read path", rd_seen, 0);
      idle_cyc(); #3;
      chk(resp_cnt[1] == 1, "R3", "forwarded single response", resp_cnt[1], 1);

      // R1 size too small, then R5 completion of single miss
      seen0 = rd_seen;
      drv(1, 2, 'h120, 32, 1, 1, 1, 0, 0);
      #3; chk(rd_seen == seen0 + 1, "R1", "smaller entry is a miss", rd_seen, seen0 + 1);
      drv(0, 0, 0, 0, 0, 0, 0, 1, 2);
      idle_cyc(); #3;
      chk(resp_cnt[2] == 1, "R5", "single miss response", resp_cnt[2], 1);

      // R1 address offset mismatch
      seen0 = rd_seen;
      drv(1, 3, 'h104, 4, 1, 1, 1, 0, 0);
      #3; chk(rd_seen == seen0 + 1, "R1", "offset address is a miss", rd_seen, seen0 + 1);
      drv(0, 0, 0, 0, 0, 0, 0, 1, 3);
      idle_cyc(); #3;

      // R3 three pieces all forwarded (equal size counts as hit)
      drv(1, 3, 'h100, 32, 1, 0, 3, 0, 0);
      drv(1, 3, 'h120, 16, 0, 0, 3, 0, 0);
      drv(1, 3, 'h200, 64, 0, 1, 3, 0, 0);
      idle_cyc(); #3;
      chk(resp_cnt[3] == 2, "R3", "all-forwarded parent response", resp_cnt[3], 2);

      // R4 mixed parent: two misses, one hit
      drv(1, 4, 'h300, 16, 1, 0, 3, 0, 0);
      drv(1, 4, 'h100, 32, 0, 0, 3, 0, 0);
      drv(1, 4, 'h340, 16, 0, 1, 3, 0, 0);
      drv(0, 0, 0, 0, 0, 0, 0, 1, 4);
      idle_cyc(); #3;
      chk(resp_cnt[4] == 0, "R4", "no response before last completion", resp_cnt[4], 0);
      drv(0, 0, 0, 0, 0, 0, 0, 1, 4);
      idle_cyc(); #3;
      chk(resp_cnt[4] == 1, "R4", "one response after last completion", resp_cnt[4], 1);

      // R7 / R8 stall on busy tag, retry on free
      drv(1, 5, 'h600, 16, 1, 0, 2, 0, 0);
      drv(1, 5, 'h640, 16, 0, 1, 2, 0, 0);
      drv(1, 5, 'h100, 32, 1, 0, 2, 0, 0);
      #2; chk(piece_ready == 0, "R7", "busy tag blocks first piece", piece_ready, 0);
      drv(0, 0, 0, 0, 0, 0, 0, 1, 5);
      drv(0, 0, 0, 0, 0, 0, 0, 1, 5);
      idle_cyc(); #3;
      chk(rd_retry == 1, "R8", "retry after entry frees", rd_retry, 1);
      chk(resp_cnt[5] == 1, "R4", "stalling parent response", resp_cnt[5], 1);
      drv(1, 5, 'h100, 32, 1, 0, 2, 0, 0);
      drv(1, 5, 'h120, 16, 0, 1, 2, 0, 0);
      idle_cyc(); #3;
      chk(resp_cnt[5] == 2, "R3", "retried parent response", resp_cnt[5], 2);
      chk(rd_retry == 0, "R8", "retry is a single pulse", rd_retry, 0);

      // R6 collision of completion and forwarded responses
      drv(1, 7, 'h700, 8, 1, 1, 1, 0, 0);
      drv(1, 0, 'h200, 64, 1, 1, 1, 1, 7);
      idle_cyc(); #3;
      chk(resp_valid && resp_tag == 7, "R6", "completion goes first", resp_tag, 7);
      chk(piece_ready == 0, "R7", "hold blocks intake", piece_ready, 0);
      idle_cyc(); #3;
      chk(resp_valid && resp_tag == 0, "R6", "forwarded follows", resp_tag, 0);

      // R4 completion and last forwarded piece in one cycle
      drv(1, 6, 'h400, 16, 1, 0, 2, 0, 0);
      drv(1, 6, 'h100, 32, 0, 1, 2, 1, 6);
      idle_cyc(); #3;
      chk(resp_cnt[6] == 1, "R4", "joint finish response", resp_cnt[6], 1);
      idle_cyc(); #3;
      chk(resp_cnt[6] == 1, "R4", "no duplicate response", resp_cnt[6], 1);

      repeat (3) idle_cyc();
      #3;
      done = 1;
      summary();
      $finish;
   end
endmodule